// File: doc/BRIEF.md
# Single-Step and Branch Trace Request Generator

This block watches the stream of instruction completion reports from a processor pipeline. It raises a trace exception request when one of two trace enables in the machine state calls for it. Each report is a one-cycle strobe. Flags on the strobe say whether the instruction was a branch, whether it was a return-from-interrupt, and whether it raised some other exception. The single-step enable and the branch-trace enable are sampled in the same cycle as the strobe.

An instruction that raised another exception never produces a trace request. The same is true of a cycle with no completion. A return-from-interrupt is exempt from single-step tracing. Branch tracing applies only to instructions marked as branches. When both kinds of trace apply to one instruction, a single request is raised, and the single-step type wins.

The request appears one clock after the completion strobe and lasts exactly one cycle. It carries a one-bit type code. Completions are not back-pressured: every strobe is accepted, and back-to-back strobes give back-to-back requests. The consumer must take each request in the cycle it is shown. Taking the exception and vectoring it belong to the consumer.

Top module: `trace_req_gen`

## Requirements
- R1: A completion with single-step enable 1, no fault flag and no return-from-interrupt flag gives a request with type code 0 (single-step). A completion with both enables 0 gives no request.
- R2: A return-from-interrupt completion never gives a single-step request. With single-step enable 1, it gives no request unless R4 applies.
- R3: A completion whose fault flag is 1 gives no request, whatever the enables and the other flags are.
- R4: A fault-free branch completion with branch-trace enable 1 gives a request with type code 1 (branch), unless R5 gives it type 0. A non-branch completion never gives a branch-type request.
- R5: When single-step and branch trace both apply to one completion, exactly one request is raised, with type code 0. A fault-free return-from-interrupt marked as a branch, with both enables 1, gives type code 1.
- R6: A cycle with the completion strobe 0 gives no request in the following cycle, whatever the enables and flags are.
- R7: The request is registered. It is high in the cycle after the strobe and for one cycle only. Consecutive strobes give consecutive requests. The enables are used only in the strobe's own cycle.
- R8: During reset, and in the first cycle after it, the request and type outputs are 0. A strobe during reset is ignored. The type output is 0 whenever the request is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | 1 | One instruction completed this cycle |
| cmp_branch | input | 1 | Completed instruction is a branch |
| cmp_rfi | input | 1 | Completed instruction is a return-from-interrupt |
| cmp_fault | input | 1 | Completed instruction raised another exception |
| step_en | input | 1 | Single-step trace enable from machine state |
| btrace_en | input | 1 | Branch trace enable from machine state |
| trc_req | output | 1 | One-cycle trace request |
| trc_kind | output | 1 | Request type: 0 single-step, 1 branch |

## Verification
Every result of this block is due one clock edge after the strobe that causes it. The bench drives each stimulus on a falling edge. The rising edge then registers it, and the outputs are compared on the next falling edge, before the next stimulus goes on the pins. The pulse-width and enable-timing cases add a further falling-edge sample one cycle later, to show that the request has dropped and that an enable changed after the strobe had no effect.

// File: rtl/trace_pkg.sv
package trace_pkg;

  typedef enum logic {
    TRC_STEP   = 1'b0,
    TRC_BRANCH = 1'b1
  } trace_kind_e;

  typedef struct packed {
    logic valid;
    logic branch;
    logic rfi;
    logic fault;
  } cmp_info_t;

  typedef struct packed {
    logic step_en;
    logic btrace_en;
  } trace_en_t;

endpackage

// File: rtl/trace_qualify.sv
module trace_qualify
  import trace_pkg::*;
(
  input  cmp_info_t   info,
  input  trace_en_t   en,
  output logic        hit,
  output trace_kind_e kind
);

  logic clean;
  logic step_hit;
  logic br_hit;

  always_comb begin
    clean    = info.valid && !info.fault;
    step_hit = clean && en.step_en && !info.rfi;
    br_hit   = clean && en.btrace_en && info.branch;
    hit      = step_hit || br_hit;
    if (step_hit)    kind = TRC_STEP;
    else if (br_hit) kind = TRC_BRANCH;
    else             kind = TRC_STEP;
  end

endmodule

// File: rtl/trace_out_reg.sv
module trace_out_reg
  import trace_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hit,
  input  trace_kind_e kind,
  output logic        req_q,
  output trace_kind_e kind_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      kind_q <= TRC_STEP;
    end else begin
      req_q  <= hit;
      kind_q <= hit ? kind : TRC_STEP;
    end
  end

endmodule

// File: rtl/trace_req_gen.sv
module trace_req_gen
  import trace_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_valid,
  input  logic cmp_branch,
  input  logic cmp_rfi,
  input  logic cmp_fault,
  input  logic step_en,
  input  logic btrace_en,
  output logic trc_req,
  output logic trc_kind
);

  cmp_info_t   info;
  trace_en_t   en;
  logic        hit;
  trace_kind_e kind;
  trace_kind_e kind_q;

  assign info = '{valid: cmp_valid, branch: cmp_branch, rfi: cmp_rfi, fault: cmp_fault};
  assign en   = '{step_en: step_en, btrace_en: btrace_en};

  trace_qualify u_qual (
    .info (info),
    .en   (en),
    .hit  (hit),
    .kind (kind)
  );

  trace_out_reg u_oreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit),
    .kind   (kind),
    .req_q  (trc_req),
    .kind_q (kind_q)
  );

  assign trc_kind = kind_q;

  // R1 / R5: a clean non-rfi completion under single-step gives a type-0 request
  a_r1_step_req: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && step_en && !cmp_fault && !cmp_rfi |=> trc_req && !trc_kind);

  // R2: an rfi without an applicable branch trace gives nothing
  a_r2_rfi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_rfi && !(btrace_en && cmp_branch) |=> !trc_req);

  // R3: a faulting completion gives nothing
  a_r3_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_fault |=> !trc_req);

  // R4: a clean traced branch with no single-step gives a type-1 request
  a_r4_branch_req: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_branch && btrace_en && !cmp_fault && !(step_en && !cmp_rfi)
    |=> trc_req && trc_kind);

  // R4: a non-branch completion never gives a branch-type request
  a_r4_nonbranch: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && !cmp_branch |=> !(trc_req && trc_kind));

  // R6: no completion, no request
  a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> !trc_req);

  // R8: the type output stays 0 while no request is shown
  a_r8_kind_rest: assert property (@(posedge clk) disable iff (!rst_n)
    !trc_req |-> !trc_kind);

endmodule

// File: tb/trace_req_gen_bench.sv
module trace_req_gen_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_valid = 1'b0, cmp_branch = 1'b0, cmp_rfi = 1'b0, cmp_fault = 1'b0;
  logic step_en = 1'b0, btrace_en = 1'b0;
  logic trc_req, trc_kind;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  trace_req_gen u_trace_req_gen (
    .clk(clk), .rst_n(rst_n),
    .cmp_valid(cmp_valid), .cmp_branch(cmp_branch), .cmp_rfi(cmp_rfi),
    .cmp_fault(cmp_fault), .step_en(step_en), .btrace_en(btrace_en),
    .trc_req(trc_req), .trc_kind(trc_kind)
  );

  // entry: {req tag[3:0], valid, branch, rfi, fault, step_en, btrace_en, exp_req, exp_kind}
  localparam int NVEC = 13;
  localparam logic [11:0] VEC [NVEC] = '{
    {4'd1, 6'b100010, 2'b10},  // R1 step on plain instruction
    {4'd1, 6'b100000, 2'b00},  // R1 both enables off
    {4'd2, 6'b101010, 2'b00},  // R2 rfi under single-step
    {4'd3, 6'b100110, 2'b00},  // R3 fault under single-step
    {4'd4, 6'b110001, 2'b11},  // R4 branch trace
    {4'd4, 6'b100001, 2'b00},  // R4 non-branch under branch trace
    {4'd3, 6'b110101, 2'b00},  // R3 faulting branch
    {4'd5, 6'b110011, 2'b10},  // R5 both apply, step wins
    {4'd5, 6'b111011, 2'b11},  // R5 rfi branch, both enables
    {4'd6, 6'b010011, 2'b00},  // R6 no strobe
    {4'd1, 6'b110010, 2'b10},  // R1 step on branch without branch trace
    {4'd3, 6'b111111, 2'b00},  // R3 everything set with fault
    {4'd2, 6'b101001, 2'b00}   // R2 rfi non-branch under branch trace
  };

  task automatic check(input int tag, input logic er, input logic ek);
    checks++;
    if (trc_req !== er || trc_kind !== ek) begin
      fails++;
      $display("FAIL R%0d: req/kind actual %b/%b expected %b/%b", tag, trc_req, trc_kind, er, ek);
    end
  endtask

  task automatic drive(input logic [5:0] v);
    {cmp_valid, cmp_branch, cmp_rfi, cmp_fault, step_en, btrace_en} = v;
  endtask

  initial begin
    // R8: reset state, strobe during reset ignored
    drive(6'b100010);
    repeat (3) @(negedge clk);
    check(8, 1'b0, 1'b0);
    drive(6'b000000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(8, 1'b0, 1'b0);  // R8 first cycle after reset

    // table walk: drive, one edge, sample
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][7:2]);
      @(negedge clk);
      check(int'(VEC[i][11:8]), VEC[i][1], VEC[i][0]);
    end
    drive(6'b000000);
    @(negedge clk);
    check(6, 1'b0, 1'b0);  // R6 idle after table

    // R7: single strobe gives a one-cycle pulse
    drive(6'b110001);
    @(negedge clk);
    drive(6'b000001);
    check(7, 1'b1, 1'b1);
    @(negedge clk);
    check(7, 1'b0, 1'b0);

    // R7: enable raised after the strobe has no effect
    drive(6'b100000);
    @(negedge clk);
    drive(6'b000010);
    check(7, 1'b0, 1'b0);
    @(negedge clk);
    check(7, 1'b0, 1'b0);

    // R7: consecutive strobes give consecutive requests
    drive(6'b100010);
    @(negedge clk);
    check(7, 1'b1, 1'b0);
    drive(6'b110011);
    @(negedge clk);
    check(7, 1'b1, 1'b0);
    drive(6'b000000);
    @(negedge clk);
    check(7, 1'b0, 1'b0);

    // R8: reset in the middle of traffic clears the pending request
    drive(6'b100010);
    rst_n = 1'b0;
    @(negedge clk);
    check(8, 1'b0, 1'b0);
    rst_n = 1'b1;
    drive(6'b000000);
    @(negedge clk);
    check(8, 1'b0, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule